// File: doc/BRIEF.md
# Per-CPU Interrupt Enable Bank

This block keeps the enable masks of an interrupt controller that serves up to 64 internal sources and two processor targets. Each processor owns a private set of mask words. From each set and the shared raw status the block forms one registered request line per processor. Software changes the masks in two ways. A plain read/write port reaches whole status and mask words. A per-source command either disables one source everywhere or enables it under an affinity set.

An enable command turns the source on only for processors that are online and named in the affinity set, and turns it off on every other processor. A processor whose mask set is marked absent is left untouched by commands, and its request line stays low. The block also decodes a programmable contiguous span of internal sources into external interrupt numbers. A second processor line carries either processor 1's request or raw external interrupt 0, chosen by the cascade enable.

Top module: `cpu_mask_bank`

## Requirements
- R1: After a synchronous reset every mask word of every processor reads zero, and `cpu_irq` and `aux_line` are low.
- R2: A command with `cmd_unmask`=0 clears the source's bit in the mask of every processor whose `cpu_present` bit is 1, from the next clock edge on.
- R3: A command with `cmd_unmask`=1 sets the source's bit for processor c when `cpu_online[c]` and `cmd_aff[c]` are both 1, and clears that bit when either is 0.
- R4: Commands leave the mask words of a processor with `cpu_present[c]`=0 unchanged. Its words stay reachable through the register port.
- R5: `cpu_irq[c]` stays low while `cpu_present[c]` is 0.
- R6: Source s lives in physical word (s/32) XOR (WORDS-1) at bit s mod 32. With 64 sources, word 0 holds sources 32..63 and word 1 holds sources 0..31. The same mapping applies to status words.
- R7: `cpu_irq[c]` is registered. It equals the OR over all words of (status AND mask) as seen at the previous clock edge, so a command shows on it two edges after it is issued.
- R8: A read with `rd_en`=1 returns its word on `rd_data` after one clock edge. `rd_sel`=0 selects the status word and `rd_sel`=1 selects the mask word of `rd_cpu`. Mask reads return the value held before any same-cycle update.
- R9: A write with `wr_en`=1 replaces the addressed mask word. A command in the same cycle that addresses a bit in that word overrides that one bit.
- R10: `query_is_ext` is registered, one edge behind its inputs. It is 1 when `casc_en` is 1 and `casc_first` <= `query_src` <= `casc_last`, and `query_ext_num` is then `query_src`-`casc_first`. Otherwise both outputs are 0.
- R11: `aux_line` is registered alongside `cpu_irq`. It carries processor 1's request when `casc_en` is 1 and the value of `ext0_i` when `casc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 64 | Raw source status, bit s is source s |
| cmd_valid | input | 1 | Per-source command strobe |
| cmd_unmask | input | 1 | 1 = enable under affinity, 0 = disable |
| cmd_src | input | 6 | Source number of the command |
| cmd_aff | input | 2 | Affinity set, bit c is processor c |
| cpu_online | input | 2 | Processor online flags |
| cpu_present | input | 2 | Processor mask set present flags |
| wr_en | input | 1 | Mask word write strobe |
| wr_cpu | input | 1 | Processor of the written word |
| wr_word | input | 1 | Physical word index of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = status word, 1 = mask word |
| rd_cpu | input | 1 | Processor of the read mask word |
| rd_word | input | 1 | Physical word index of the read |
| rd_data | output | 32 | Registered read data |
| casc_en | input | 1 | Cascade enable |
| casc_first | input | 6 | First cascaded source |
| casc_last | input | 6 | Last cascaded source |
| query_src | input | 6 | Source to decode |
| query_is_ext | output | 1 | Queried source is a cascaded external |
| query_ext_num | output | 6 | External number of the queried source |
| ext0_i | input | 1 | Raw external interrupt 0 |
| cpu_irq | output | 2 | Registered per-processor request |
| aux_line | output | 1 | Second processor line |

## Verification
A bad bit in a mask word shows up at two places. A port read returns it after one edge. `cpu_irq` reports it two edges after a command once the matching status bit is driven. Because of this, every source is swept with a command and then read back from both processors, and every source is also driven alone on the status input to watch the request line. A wrong word or bit mapping makes a neighbouring bit move. A command that leaks into an absent processor changes the words written there earlier. Errors in the cascade decode and the line selection show on the output one edge after the inputs are applied.

// File: rtl/imb_pkg.sv
package imb_pkg;
  typedef enum logic {OP_DISABLE = 1'b0, OP_ENABLE = 1'b1} op_e;
  typedef enum logic {RSEL_STATUS = 1'b0, RSEL_MASK = 1'b1} rsel_e;
endpackage

// File: rtl/imb_index.sv
module imb_index #(
  parameter int NUM_SRC = 64,
  parameter int DW      = 32,
  localparam int WORDS  = NUM_SRC / DW,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int BIT_W  = $clog2(DW),
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [SRC_W-1:0]  src,
  output logic [WORD_W-1:0] word,
  output logic [BIT_W-1:0]  bitpos
);
  assign bitpos = src[BIT_W-1:0];
  generate
    if (WORDS > 1) begin : g_multi
      // Highest source group lands in physical word 0.
      assign word = src[SRC_W-1:BIT_W] ^ WORD_W'(WORDS - 1);
    end else begin : g_single
      assign word = '0;
    end
  endgenerate
endmodule

// File: rtl/imb_mask_store.sv
module imb_mask_store #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int DW      = 32,
  localparam int WORDS  = NUM_SRC / DW,
  localparam int BIT_W  = $clog2(DW),
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic                        cmd_op,
  input  logic [WORD_W-1:0]           cmd_word,
  input  logic [BIT_W-1:0]            cmd_bit,
  input  logic [NUM_CPU-1:0]          cmd_aff,
  input  logic [NUM_CPU-1:0]          cpu_online,
  input  logic [NUM_CPU-1:0]          cpu_present,
  input  logic                        wr_en,
  input  logic [CPU_W-1:0]            wr_cpu,
  input  logic [WORD_W-1:0]           wr_word,
  input  logic [DW-1:0]               wr_data,
  output logic [NUM_CPU*WORDS*DW-1:0] masks_flat
);
  import imb_pkg::*;

  logic [DW-1:0] mem [NUM_CPU][WORDS];
  logic [DW-1:0] nxt [NUM_CPU][WORDS];

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        nxt[c][w] = mem[c][w];
        if (wr_en && wr_cpu == CPU_W'(c) && wr_word == WORD_W'(w))
          nxt[c][w] = wr_data;
        if (cmd_valid && cpu_present[c] && cmd_word == WORD_W'(w)) begin
          if (op_e'(cmd_op) == OP_ENABLE)
            nxt[c][w][cmd_bit] = cpu_online[c] & cmd_aff[c];
          else
            nxt[c][w][cmd_bit] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int w = 0; w < WORDS; w++)
        if (rst) mem[c][w] <= '0;
        else     mem[c][w] <= nxt[c][w];
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int w = 0; w < WORDS; w++)
        masks_flat[(c*WORDS+w)*DW +: DW] = mem[c][w];
  end

  // Checker copies of the last command fields.
  logic [WORD_W-1:0]  chk_word;
  logic [BIT_W-1:0]   chk_bit;
  logic [NUM_CPU-1:0] chk_en;
  always_ff @(posedge clk) begin
    chk_word <= cmd_word;
    chk_bit  <= cmd_bit;
    chk_en   <= cpu_online & cmd_aff;
  end

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
      assert_disable_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cpu_present[c] && !cmd_op) |=> (mem[c][chk_word][chk_bit] == 1'b0));
      assert_enable_affinity_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cpu_present[c] && cmd_op) |=> (mem[c][chk_word][chk_bit] == chk_en[c]));
      assert_absent_untouched_R4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_present[c] && !(wr_en && wr_cpu == CPU_W'(c)))
          |=> $stable(masks_flat[c*WORDS*DW +: WORDS*DW]));
    end
  endgenerate
endmodule

// File: rtl/imb_reduce.sv
module imb_reduce #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int DW      = 32,
  localparam int WORDS  = NUM_SRC / DW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CPU*WORDS*DW-1:0] masks_flat,
  input  logic [NUM_SRC-1:0]          status_i,
  input  logic [NUM_CPU-1:0]          cpu_present,
  input  logic                        casc_en,
  input  logic                        ext0_i,
  output logic [NUM_CPU-1:0]          cpu_irq,
  output logic                        aux_line
);
  logic [NUM_CPU-1:0] irq_n;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      irq_n[c] = 1'b0;
      for (int w = 0; w < WORDS; w++)
        irq_n[c] = irq_n[c] |
          (|(masks_flat[(c*WORDS+w)*DW +: DW] & status_i[(w ^ (WORDS-1))*DW +: DW]));
      irq_n[c] = irq_n[c] & cpu_present[c];
    end
  end

  logic aux_n;
  generate
    if (NUM_CPU > 1) begin : g_aux
      assign aux_n = casc_en ? irq_n[1] : ext0_i;
    end else begin : g_aux1
      assign aux_n = casc_en ? 1'b0 : ext0_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq  <= '0;
      aux_line <= 1'b0;
    end else begin
      cpu_irq  <= irq_n;
      aux_line <= aux_n;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
      assert_absent_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !cpu_present[c] |=> !cpu_irq[c]);
    end
  endgenerate
  assert_no_status_no_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (status_i == '0) |=> (cpu_irq == '0));
  assert_aux_follows_ext_R11: assert property (@(posedge clk) disable iff (rst)
    !casc_en |=> (aux_line == $past(ext0_i)));
endmodule

// File: rtl/imb_cascade.sv
module imb_cascade #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             casc_en,
  input  logic [SRC_W-1:0] casc_first,
  input  logic [SRC_W-1:0] casc_last,
  input  logic [SRC_W-1:0] query_src,
  output logic             query_is_ext,
  output logic [SRC_W-1:0] query_ext_num
);
  logic in_span;
  assign in_span = casc_en && (query_src >= casc_first) && (query_src <= casc_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      query_is_ext  <= 1'b0;
      query_ext_num <= '0;
    end else begin
      query_is_ext  <= in_span;
      query_ext_num <= in_span ? (query_src - casc_first) : '0;
    end
  end

  assert_off_no_hit_R10: assert property (@(posedge clk) disable iff (rst)
    !casc_en |=> (!query_is_ext && query_ext_num == '0));
  assert_num_in_span_R10: assert property (@(posedge clk) disable iff (rst)
    query_is_ext |-> (query_ext_num <= $past(casc_last - casc_first)));
endmodule

// File: rtl/cpu_mask_bank.sv
module cpu_mask_bank #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int DW      = 32,
  localparam int WORDS  = NUM_SRC / DW,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int BIT_W  = $clog2(DW),
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               cmd_valid,
  input  logic               cmd_unmask,
  input  logic [SRC_W-1:0]   cmd_src,
  input  logic [NUM_CPU-1:0] cmd_aff,
  input  logic [NUM_CPU-1:0] cpu_online,
  input  logic [NUM_CPU-1:0] cpu_present,
  input  logic               wr_en,
  input  logic [CPU_W-1:0]   wr_cpu,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic               rd_sel,
  input  logic [CPU_W-1:0]   rd_cpu,
  input  logic [WORD_W-1:0]  rd_word,
  output logic [DW-1:0]      rd_data,
  input  logic               casc_en,
  input  logic [SRC_W-1:0]   casc_first,
  input  logic [SRC_W-1:0]   casc_last,
  input  logic [SRC_W-1:0]   query_src,
  output logic               query_is_ext,
  output logic [SRC_W-1:0]   query_ext_num,
  input  logic               ext0_i,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic               aux_line
);
  import imb_pkg::*;

  logic [WORD_W-1:0]            cmd_word;
  logic [BIT_W-1:0]             cmd_bit;
  logic [NUM_CPU*WORDS*DW-1:0]  masks_flat;

  imb_index #(.NUM_SRC(NUM_SRC), .DW(DW)) u_index (
    .src(cmd_src), .word(cmd_word), .bitpos(cmd_bit)
  );

  imb_mask_store #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_unmask), .cmd_word(cmd_word), .cmd_bit(cmd_bit),
    .cmd_aff(cmd_aff), .cpu_online(cpu_online), .cpu_present(cpu_present),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_word(wr_word), .wr_data(wr_data),
    .masks_flat(masks_flat)
  );

  imb_reduce #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .DW(DW)) u_reduce (
    .clk(clk), .rst(rst), .masks_flat(masks_flat), .status_i(status_i),
    .cpu_present(cpu_present), .casc_en(casc_en), .ext0_i(ext0_i),
    .cpu_irq(cpu_irq), .aux_line(aux_line)
  );

  imb_cascade #(.NUM_SRC(NUM_SRC)) u_casc (
    .clk(clk), .rst(rst), .casc_en(casc_en), .casc_first(casc_first),
    .casc_last(casc_last), .query_src(query_src),
    .query_is_ext(query_is_ext), .query_ext_num(query_ext_num)
  );

  // Register read port: status words use the same reversed word order.
  logic [WORD_W-1:0] rd_grp;
  logic [DW-1:0]     rd_mux;
  assign rd_grp = rd_word ^ WORD_W'(WORDS - 1);

  always_comb begin
    if (rsel_e'(rd_sel) == RSEL_STATUS)
      rd_mux = status_i[int'(rd_grp)*DW +: DW];
    else
      rd_mux = masks_flat[(int'(rd_cpu)*WORDS + int'(rd_word))*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/cpu_mask_bank_bench.sv
module cpu_mask_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] status_i;
  logic        cmd_valid, cmd_unmask;
  logic [5:0]  cmd_src;
  logic [1:0]  cmd_aff, cpu_online, cpu_present;
  logic        wr_en, wr_cpu, wr_word;
  logic [31:0] wr_data;
  logic        rd_en, rd_sel, rd_cpu, rd_word;
  logic [31:0] rd_data;
  logic        casc_en;
  logic [5:0]  casc_first, casc_last, query_src, query_ext_num;
  logic        query_is_ext, ext0_i, aux_line;
  logic [1:0]  cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] model [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_mask_bank u_cpu_mask_bank (
    .clk(clk), .rst(rst), .status_i(status_i),
    .cmd_valid(cmd_valid), .cmd_unmask(cmd_unmask), .cmd_src(cmd_src), .cmd_aff(cmd_aff),
    .cpu_online(cpu_online), .cpu_present(cpu_present),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_word(wr_word), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_cpu(rd_cpu), .rd_word(rd_word), .rd_data(rd_data),
    .casc_en(casc_en), .casc_first(casc_first), .casc_last(casc_last),
    .query_src(query_src), .query_is_ext(query_is_ext), .query_ext_num(query_ext_num),
    .ext0_i(ext0_i), .cpu_irq(cpu_irq), .aux_line(aux_line)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // Word w of a source-indexed vector (R6 mapping, 2 words).
  function automatic logic [31:0] word_of(input logic [63:0] v, input int w);
    return v[((w ^ 1) * 32) +: 32];
  endfunction

  task automatic cmd(input bit en, input int src, input logic [1:0] aff);
    cmd_valid = 1; cmd_unmask = en; cmd_src = 6'(src); cmd_aff = aff;
    for (int c = 0; c < 2; c++)
      if (cpu_present[c]) model[c][src] = en ? (cpu_online[c] & aff[c]) : 1'b0;
    tick();
    cmd_valid = 0;
  endtask

  task automatic wr(input int c, input int w, input logic [31:0] d);
    wr_en = 1; wr_cpu = c[0]; wr_word = w[0]; wr_data = d;
    model[c][((w ^ 1) * 32) +: 32] = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input bit sel, input int c, input int w, output logic [31:0] d);
    rd_en = 1; rd_sel = sel; rd_cpu = c[0]; rd_word = w[0];
    tick();
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic check_masks(input string req);
    logic [31:0] d;
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++) begin
        rd(1, c, w, d);
        check(d == word_of(model[c], w), req, 64'(d), 64'(word_of(model[c], w)));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1; status_i = '0; cmd_valid = 0; cmd_unmask = 0; cmd_src = '0; cmd_aff = '0;
    cpu_online = 2'b11; cpu_present = 2'b11; wr_en = 0; wr_cpu = 0; wr_word = 0;
    wr_data = '0; rd_en = 0; rd_sel = 0; rd_cpu = 0; rd_word = 0; casc_en = 0;
    casc_first = '0; casc_last = '0; query_src = '0; ext0_i = 0;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    check(cpu_irq == 2'b00, "R1 irq", 64'(cpu_irq), 0);
    check(aux_line == 1'b0, "R1 aux", 64'(aux_line), 0);
    check_masks("R1 mask");

    // R3 R6: enable sweep with affinity and online patterns
    for (int s = 0; s < 64; s++)
      for (int a = 0; a < 4; a++) begin
        cpu_online = 2'((s + a) % 4);
        cmd(1, s, 2'(a));
        for (int c = 0; c < 2; c++) begin
          rd(1, c, (s / 32) ^ 1, d);
          check(d == word_of(model[c], (s / 32) ^ 1), "R3 R6 enable", 64'(d),
                64'(word_of(model[c], (s / 32) ^ 1)));
        end
      end
    cpu_online = 2'b11;

    // R2: disable sweep from all ones
    for (int c = 0; c < 2; c++) for (int w = 0; w < 2; w++) wr(c, w, 32'hFFFF_FFFF);
    for (int s = 0; s < 64; s++) begin
      cmd(0, s, 2'b11);
      for (int c = 0; c < 2; c++) begin
        rd(1, c, (s / 32) ^ 1, d);
        check(d == word_of(model[c], (s / 32) ^ 1), "R2 disable", 64'(d),
              64'(word_of(model[c], (s / 32) ^ 1)));
      end
    end

    // R4 R5: absent processor
    wr(1, 0, 32'hA5A5_0F0F);
    wr(1, 1, 32'h1234_5678);
    cpu_present = 2'b01;
    cmd(1, 5, 2'b11);
    cmd(0, 40, 2'b11);
    cmd(1, 33, 2'b10);
    check_masks("R4 absent");
    status_i = '1;
    tick(); tick();
    check(cpu_irq[1] == 1'b0, "R5 absent irq", 64'(cpu_irq), 64'(cpu_irq & 2'b01));
    cpu_present = 2'b11;
    tick(); tick();
    check(cpu_irq[1] == 1'b1, "R5 present irq", 64'(cpu_irq[1]), 1);

    // R7: request per source
    for (int c = 0; c < 2; c++) for (int w = 0; w < 2; w++) wr(c, w, 32'h0);
    for (int s = 0; s < 64; s++) begin
      status_i = 64'd1 << s;
      cmd(1, s, 2'b01);
      tick();
      check(cpu_irq == 2'b01, "R7 hit", 64'(cpu_irq), 1);
      status_i = ~(64'd1 << s);
      tick(); tick();
      check(cpu_irq == 2'b00, "R7 miss", 64'(cpu_irq), 0);
      cmd(0, s, 2'b11);
    end

    // R8: status read with word order
    status_i = {32'hDEAD_BEEF, 32'h0123_4567};
    rd(0, 0, 0, d);
    check(d == 32'hDEAD_BEEF, "R8 status w0", 64'(d), 64'h DEAD_BEEF);
    rd(0, 1, 1, d);
    check(d == 32'h0123_4567, "R8 status w1", 64'(d), 64'h0123_4567);

    // R9: write and command in the same cycle
    wr_en = 1; wr_cpu = 0; wr_word = 0; wr_data = 32'hFFFF_FFFF;
    cmd_valid = 1; cmd_unmask = 0; cmd_src = 6'd33; cmd_aff = 2'b11;
    tick();
    wr_en = 0; cmd_valid = 0;
    rd(1, 0, 0, d);
    check(d == 32'hFFFF_FFFD, "R9 collide", 64'(d), 64'hFFFF_FFFD);

    // R10: cascade decode sweep
    casc_first = 6'd40; casc_last = 6'd45;
    for (int e = 0; e < 2; e++) begin
      casc_en = e[0];
      for (int q = 0; q < 64; q++) begin
        bit hit;
        query_src = 6'(q);
        tick();
        hit = (e == 1) && q >= 40 && q <= 45;
        check(query_is_ext == hit, "R10 hit", 64'(query_is_ext), 64'(hit));
        check(query_ext_num == (hit ? 6'(q - 40) : 6'd0), "R10 num",
              64'(query_ext_num), hit ? 64'(q - 40) : 0);
      end
    end

    // R11: second line selection
    for (int c = 0; c < 2; c++) for (int w = 0; w < 2; w++) wr(c, w, 32'h0);
    status_i = 64'd1 << 7;
    casc_en = 0;
    for (int k = 0; k < 4; k++) begin
      ext0_i = k[0];
      tick();
      check(aux_line == k[0], "R11 ext", 64'(aux_line), 64'(k[0]));
    end
    casc_en = 1; ext0_i = 0;
    cmd(1, 7, 2'b10);
    tick();
    check(aux_line == 1'b1 && cpu_irq == 2'b10, "R11 casc", {62'd0, aux_line, cpu_irq[1]}, 64'd3);
    ext0_i = 1;
    cmd(0, 7, 2'b11);
    tick();
    check(aux_line == 1'b0, "R11 casc off", 64'(aux_line), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule